// File: doc/BRIEF.md
# Programmable Interval Down-Counter

This block is a down-counting interval timer controlled through a small bank of word-addressed registers on a simple synchronous read/write bus. Software picks a reload period and a mode (repeating or single-shot), starts and stops the count, and can read or overwrite the live count at any time. A separate clock-enable input, `tick_en`, sets the count rate. The block itself has no prescaler.

Each expiry sets a sticky interrupt flag. The flag is gated by an enable bit onto a single level-sensitive interrupt line, and software clears it by writing a one to it. A constant identification word and a constant frequency word can be read back so that drivers can recognise the block and scale their periods. Accesses to unmapped indices, and writes to the constant registers, are dropped and produce a one-cycle error strobe.

Top module: `ivl_timer`

## Requirements
- R1: The register index is `bus_addr[11:2]`. Address bits above bit 11 and the two lowest bits are ignored. The indices are: 0 identity, 1 run control, 2 mode (nonzero = single-shot), 3 period, 4 live count, 5 interrupt enable, 6 interrupt flag, 7 frequency.
- R2: Reading index 0 returns `ID_VALUE` and reading index 7 returns `FREQ_VALUE`. Writes to either index change nothing.
- R3: Writing the period register stores the word and loads the same word into the live count in the same cycle.
- R4: Writing the live-count register replaces the count and leaves the period unchanged.
- R5: While the run bit is 1, each cycle with `tick_en` high lowers a nonzero count by one. While the run bit is 0, the count holds. Writing a nonzero word sets the run bit to 1 and writing zero clears it. A count of 0 never wraps.
- R6: An expiry is a tick that takes the count from 1 to 0 while the period is nonzero. In repeating mode the count reloads from the period and the interrupt flag (bit 0 of index 6) is set.
- R7: On an expiry in single-shot mode the count stays at 0, the run bit clears and the interrupt flag is set.
- R8: Writing the mode register while running leaves the run bit and the count untouched. The new mode governs the next expiry.
- R9: While the period is 0, no expiry happens. The count runs down to 0 and the flag stays clear.
- R10: Writing index 6 clears the flag when bit 0 of the written word is 1 and leaves it alone when bit 0 is 0. An expiry in the same cycle as a clearing write leaves the flag set.
- R11: `irq` is high exactly when the flag and bit 0 of the interrupt-enable register (index 5) are both 1.
- R12: An access to an index above 7, or a write to index 0 or 7, changes no state and reads as 0. `bus_err` is high for one cycle, in the cycle after such an access.
- R13: After reset the count, period, run bit, mode, enable and flag are all 0, and `irq` and `bus_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Count-rate enable, one pulse per count step |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational while `bus_sel` is high |
| bus_err | output | 1 | One-cycle strobe after an invalid access |
| irq | output | 1 | Level interrupt |

## Verification
Two events can fall in the same clock edge: an expiry that sets the interrupt flag and a software write that clears it. The bench sets the count to 1 with the timer running and a nonzero period. It then raises `tick_en` in the same cycle as a write of 1 to the flag register. It judges the result by reading the flag back as 1 and the count back as the reloaded period. A second clearing write with no tick must then read back 0.

// File: rtl/ivt_pkg.sv
// Shared definitions for the interval timer: register indices and the
// per-register write strobe bundle. Assumes an 8-entry register map.
package ivt_pkg;

    localparam int unsigned NUM_REGS = 8;
    localparam int unsigned WIN_MSB  = 11;   // top bit of the 4 KiB window

    typedef enum logic [2:0] {
        REG_ID    = 3'd0,
        REG_RUN   = 3'd1,
        REG_MODE  = 3'd2,
        REG_LIMIT = 3'd3,
        REG_COUNT = 3'd4,
        REG_IEN   = 3'd5,
        REG_ISTAT = 3'd6,
        REG_FREQ  = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic run;
        logic mode;
        logic limit;
        logic count;
        logic ien;
        logic istat;
    } wr_stb_t;

endpackage

// File: rtl/ivt_regbank.sv
// Register decoder: turns a bus access into per-register write strobes,
// muxes read data and flags invalid accesses. Assumes ADDR_W >= 12 and
// a single-cycle access qualified by sel.
module ivt_regbank
    import ivt_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned DATA_W     = 32,
    parameter logic [DATA_W-1:0] ID_VALUE   = '0,
    parameter logic [DATA_W-1:0] FREQ_VALUE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic              run_q,
    input  logic              mode_q,
    input  logic [DATA_W-1:0] limit_q,
    input  logic [DATA_W-1:0] count_q,
    input  logic              ien_q,
    input  logic              istat_q,
    output wr_stb_t           stb,
    output logic [DATA_W-1:0] rdata,
    output logic              err
);

    localparam int unsigned IDX_W = WIN_MSB - 1;   // address bits 11..2

    logic [IDX_W-1:0] idx_full;
    logic [2:0]       idx;
    logic             in_range;
    logic             ro_write;
    logic             bad;
    logic             ok_wr;
    logic             unused_addr;

    assign idx_full    = addr[WIN_MSB:2];
    assign idx         = idx_full[2:0];
    assign in_range    = (idx_full < IDX_W'(NUM_REGS));
    assign ro_write    = we && ((idx == REG_ID) || (idx == REG_FREQ));
    assign bad         = !in_range || ro_write;
    assign ok_wr       = sel && we && !bad;
    assign unused_addr = ^{addr[ADDR_W-1:WIN_MSB+1], addr[1:0]};

    // Write strobes, one per writable register
    always_comb begin
        stb       = '0;
        stb.run   = ok_wr && (idx == REG_RUN);
        stb.mode  = ok_wr && (idx == REG_MODE);
        stb.limit = ok_wr && (idx == REG_LIMIT);
        stb.count = ok_wr && (idx == REG_COUNT);
        stb.ien   = ok_wr && (idx == REG_IEN);
        stb.istat = ok_wr && (idx == REG_ISTAT);
    end

    // Read data mux; zero for invalid indices
    always_comb begin
        rdata = '0;
        if (in_range) begin
            case (idx)
                REG_ID:    rdata = ID_VALUE;
                REG_RUN:   rdata = {{(DATA_W-1){1'b0}}, run_q};
                REG_MODE:  rdata = {{(DATA_W-1){1'b0}}, mode_q};
                REG_LIMIT: rdata = limit_q;
                REG_COUNT: rdata = count_q;
                REG_IEN:   rdata = {{(DATA_W-1){1'b0}}, ien_q};
                REG_ISTAT: rdata = {{(DATA_W-1){1'b0}}, istat_q};
                default:   rdata = FREQ_VALUE;
            endcase
        end
    end

    // Error strobe, registered one cycle after the bad access
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= sel && bad;
    end

endmodule

// File: rtl/ivt_core.sv
// Counter core: holds period, live count, run bit and mode, and raises
// a combinational expiry pulse. Assumes strobes are mutually exclusive.
module ivt_core
    import ivt_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  wr_stb_t           stb,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] count_q,
    output logic [DATA_W-1:0] limit_q,
    output logic              run_q,
    output logic              mode_q,
    output logic              expire
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic cnt_written;
    logic step;

    assign cnt_written = stb.limit || stb.count;
    assign step        = run_q && tick && !cnt_written;
    assign expire      = step && (count_q == ONE) && (limit_q != '0);

    // Run bit: software write wins, else single-shot expiry clears it
    always_ff @(posedge clk) begin
        if (!rst_n)                 run_q <= 1'b0;
        else if (stb.run)           run_q <= |wdata;
        else if (expire && mode_q)  run_q <= 1'b0;
    end

    // Mode bit: 1 = single-shot
    always_ff @(posedge clk) begin
        if (!rst_n)        mode_q <= 1'b0;
        else if (stb.mode) mode_q <= |wdata;
    end

    // Period register
    always_ff @(posedge clk) begin
        if (!rst_n)         limit_q <= '0;
        else if (stb.limit) limit_q <= wdata;
    end

    // Live count: writes, then expiry reload, then plain decrement
    always_ff @(posedge clk) begin
        if (!rst_n)                      count_q <= '0;
        else if (cnt_written)            count_q <= wdata;
        else if (expire)                 count_q <= mode_q ? '0 : limit_q;
        else if (step && count_q != '0)  count_q <= count_q - ONE;
    end

endmodule

// File: rtl/ivt_irq.sv
// Interrupt unit: sticky flag set by expiry, write-one-to-clear, gated
// by an enable bit. Set has priority over a same-cycle clear.
module ivt_irq
    import ivt_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    expire,
    input  wr_stb_t stb,
    input  logic    wbit,
    output logic    ien_q,
    output logic    istat_q,
    output logic    irq
);

    // Interrupt enable bit
    always_ff @(posedge clk) begin
        if (!rst_n)       ien_q <= 1'b0;
        else if (stb.ien) ien_q <= wbit;
    end

    // Sticky flag with write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n) istat_q <= 1'b0;
        else        istat_q <= expire || (istat_q && !(stb.istat && wbit));
    end

    assign irq = ien_q && istat_q;

endmodule

// File: rtl/ivl_timer.sv
// Top of the interval timer: wires the decoder, counter core and
// interrupt unit. Assumes one bus access per cycle and a synchronous
// active-low reset.
module ivl_timer
    import ivt_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned DATA_W     = 32,
    parameter logic [DATA_W-1:0] ID_VALUE   = DATA_W'(32'h7131_0A01),
    parameter logic [DATA_W-1:0] FREQ_VALUE = DATA_W'(32'd1_000_000)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic              irq
);

    wr_stb_t           stb;
    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] limit_q;
    logic              run_q;
    logic              mode_q;
    logic              ien_q;
    logic              istat_q;
    logic              expire;

    ivt_regbank #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .ID_VALUE(ID_VALUE), .FREQ_VALUE(FREQ_VALUE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(bus_sel), .we(bus_we),
        .addr(bus_addr), .run_q(run_q), .mode_q(mode_q),
        .limit_q(limit_q), .count_q(count_q), .ien_q(ien_q),
        .istat_q(istat_q), .stb(stb), .rdata(bus_rdata), .err(bus_err)
    );

    ivt_core #(.DATA_W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick_en), .stb(stb),
        .wdata(bus_wdata), .count_q(count_q), .limit_q(limit_q),
        .run_q(run_q), .mode_q(mode_q), .expire(expire)
    );

    ivt_irq u_irq (
        .clk(clk), .rst_n(rst_n), .expire(expire), .stb(stb),
        .wbit(bus_wdata[0]), .ien_q(ien_q), .istat_q(istat_q), .irq(irq)
    );

endmodule

// File: rtl/ivt_chk.sv
// Property checker for the interval timer, bound to ivl_timer. Observes
// bus ports plus the count, run bit and flag registers.
module ivt_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_err,
    input logic              irq,
    input logic [DATA_W-1:0] count_q,
    input logic              run_q,
    input logic              istat_q
);

    logic [9:0] c_idx;
    logic       c_bad;
    logic       c_wr;

    assign c_idx = bus_addr[11:2];
    assign c_bad = bus_sel && ((c_idx > 10'd7) ||
                   (bus_we && (c_idx == 10'd0 || c_idx == 10'd7)));
    assign c_wr  = bus_sel && bus_we && !c_bad;

    // R12
    bad_access_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_bad |=> bus_err);

    // R12
    err_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_bad) |=> !bus_err);

    // R3
    limit_loads_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr && c_idx == 10'd3) |=> (count_q == $past(bus_wdata)));

    // R5
    stopped_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !c_wr) |=> $stable(count_q));

    // R7
    run_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_q) |-> ($past(tick_en) || $past(c_wr)));

    // R10
    flag_rise_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(istat_q) |-> $past(tick_en));

    // R11
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(tick_en) || $past(c_wr)));

endmodule

bind ivl_timer ivt_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_err(bus_err), .irq(irq), .count_q(count_q), .run_q(run_q),
    .istat_q(istat_q)
);

// File: tb/tb_ivl_timer.sv
// Directed bench for ivl_timer: one task per scenario, each checking
// its own results through the bus and the irq/err pins.
module tb_ivl_timer;

    localparam logic [31:0] TB_ID   = 32'h7131_0A01;
    localparam logic [31:0] TB_FREQ = 32'd50_000_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        irq;

    int checks = 0;
    int errors = 0;

    ivl_timer #(.ID_VALUE(TB_ID), .FREQ_VALUE(TB_FREQ)) dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .irq(irq)
    );

    always #10 clk = ~clk;   // 50 MHz

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_a(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        wr_a(32'(idx) << 2, d);
    endtask

    task automatic rd_a(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int idx, input logic [31:0] exp);
        logic [31:0] d;
        rd_a(32'(idx) << 2, d);
        chk(tag, d, exp);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic t_reset;
        chk("R13 irq", {31'b0, irq}, 32'd0);
        chk("R13 err", {31'b0, bus_err}, 32'd0);
        rd_chk("R13 count", 4, 0);
        rd_chk("R13 limit", 3, 0);
        rd_chk("R13 run", 1, 0);
        rd_chk("R13 mode", 2, 0);
        rd_chk("R13 ien", 5, 0);
        rd_chk("R13 flag", 6, 0);
    endtask

    task automatic t_consts;
        rd_chk("R2 id", 0, TB_ID);
        rd_chk("R2 freq", 7, TB_FREQ);
        wr(7, 32'd123);
        chk("R12 err after freq write", {31'b0, bus_err}, 32'd1);
        rd_chk("R2 freq unchanged", 7, TB_FREQ);
        wr(0, 32'd5);
        chk("R12 err after id write", {31'b0, bus_err}, 32'd1);
        rd_chk("R2 id unchanged", 0, TB_ID);
    endtask

    task automatic t_load;
        wr(3, 32'd5);
        rd_chk("R3 count loaded", 4, 5);
        rd_chk("R3 limit stored", 3, 5);
        wr(4, 32'd3);
        rd_chk("R4 count written", 4, 3);
        rd_chk("R4 limit kept", 3, 5);
    endtask

    task automatic t_periodic;
        ticks(2);
        rd_chk("R5 stopped holds", 4, 3);
        wr(1, 32'd1);
        rd_chk("R5 run bit", 1, 1);
        ticks(2);
        rd_chk("R5 decrement", 4, 1);
        ticks(1);
        rd_chk("R6 reload", 4, 5);
        rd_chk("R6 flag set", 6, 1);
        chk("R11 irq masked", {31'b0, irq}, 32'd0);
        wr(5, 32'd1);
        chk("R11 irq on", {31'b0, irq}, 32'd1);
        wr(6, 32'd0);
        rd_chk("R10 zero keeps flag", 6, 1);
        wr(6, 32'd1);
        rd_chk("R10 one clears flag", 6, 0);
        chk("R11 irq off", {31'b0, irq}, 32'd0);
        wr(1, 32'd0);
        ticks(3);
        rd_chk("R5 stop holds count", 4, 5);
    endtask

    task automatic t_oneshot;
        wr(2, 32'd1);
        wr(4, 32'd2);
        wr(1, 32'd1);
        ticks(3);
        rd_chk("R7 count stays 0", 4, 0);
        rd_chk("R7 run cleared", 1, 0);
        rd_chk("R7 flag set", 6, 1);
        chk("R11 irq oneshot", {31'b0, irq}, 32'd1);
        wr(6, 32'd1);
    endtask

    task automatic t_mode_switch;
        wr(2, 32'd0);
        wr(3, 32'd4);
        wr(1, 32'd1);
        ticks(1);
        wr(2, 32'd1);
        rd_chk("R8 still running", 1, 1);
        rd_chk("R8 count kept", 4, 3);
        ticks(3);
        rd_chk("R8 new mode stops", 1, 0);
        rd_chk("R8 count 0", 4, 0);
        wr(6, 32'd1);
    endtask

    task automatic t_zero_limit;
        wr(2, 32'd0);
        wr(3, 32'd0);
        wr(4, 32'd2);
        wr(1, 32'd1);
        ticks(4);
        rd_chk("R9 count at 0", 4, 0);
        rd_chk("R9 no flag", 6, 0);
        rd_chk("R9 still running", 1, 1);
    endtask

    task automatic t_same_cycle;
        wr(3, 32'd4);
        wr(4, 32'd1);
        @(negedge clk);
        tick_en = 1'b1;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 32'd6 << 2; bus_wdata = 32'd1;
        @(negedge clk);
        tick_en = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
        rd_chk("R10 set beats clear", 6, 1);
        rd_chk("R6 reload same cycle", 4, 4);
        wr(6, 32'd1);
        rd_chk("R10 clear alone", 6, 0);
    endtask

    task automatic t_invalid;
        logic [31:0] d;
        rd_a(32'h24, d);
        chk("R12 bad read zero", d, 0);
        chk("R12 bad read err", {31'b0, bus_err}, 32'd1);
        wr(8, 32'd7);
        chk("R12 bad write err", {31'b0, bus_err}, 32'd1);
        rd_chk("R12 limit untouched", 3, 4);
        chk("R12 good read no err", {31'b0, bus_err}, 32'd0);
        wr_a(32'h0000_100C, 32'd9);
        chk("R1 masked write no err", {31'b0, bus_err}, 32'd0);
        rd_chk("R1 window mask", 3, 9);
        rd_a(32'h0000_000E, d);
        chk("R1 low bits ignored", d, 9);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_consts();
        t_load();
        t_periodic();
        t_oneshot();
        t_mode_switch();
        t_zero_limit();
        t_same_cycle();
        t_invalid();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule